// File: doc/BRIEF.md
# UART Receive/Transmit Data Register with Receive-Full Status

This block holds the data and receive status of a serial port. It sits between a receive shift register and a processor bus. A read and a write at one bus address go to two different storage registers. A read returns the most recently captured received character. A write loads the character that the transmit side will send next.

When the receive shifter signals that a character is complete, the block captures the byte. It then sets a receive-full flag and, if the interrupt is enabled, requests a receive interrupt. In 7-bit character mode the top bit of the stored byte is forced low.

The block also keeps three sticky error flags: parity, framing and overrun. An overrun occurs when a character arrives while the previous one is still unread; the older byte is kept. The error flags are cleared only by a dedicated strobe. A break-detected input discards any pending character. While any error flag is set, the receive interrupt stays asserted, so software must service the error. Shifting, baud generation and transmit serialisation are outside the block; they appear here as strobe and data ports.

Top module: `sio_data_port`

## Requirements
- R1: `bus_rdata` always shows the receive register. A `bus_wr` strobe loads `bus_wdata` into `tx_data` at the next edge and leaves the receive register unchanged. A `bus_rd` strobe leaves `tx_data` unchanged.
- R2: After reset, `bus_rdata` is 0x00, `tx_data` is 0xFF, and `rx_full`, `par_err`, `ovr_err`, `frm_err` and `rx_irq` are all 0.
- R3: With `char7_mode`=1, bit 7 of the stored byte is 0 and bits 6..0 equal `rx_byte`. With `char7_mode`=0, all 8 bits are stored unchanged.
- R4: An `rx_done` strobe without `brk_det` stores the byte and sets `rx_full` at the next edge, provided `rx_full` was 0 or `bus_rd` is high in the same cycle.
- R5: `rx_irq` is 1 exactly when `rx_irq_en`=1 and at least one of `rx_full`, `par_err`, `ovr_err` or `frm_err` is 1. With `rx_irq_en`=0 it stays 0.
- R6: A `bus_rd` clears `rx_full` at the next edge. If `bus_rd` and `rx_done` coincide, the new byte is stored, `rx_full` stays 1 and no overrun is flagged.
- R7: A read taken while an error flag is set leaves `rx_irq` asserted (when enabled).
- R8: `brk_det` clears `rx_full` at the next edge. An `rx_done` in the same cycle is ignored: no store and no flag change.
- R9: An `rx_done` while `rx_full`=1 and no `bus_rd` sets `ovr_err`. In that case the stored byte is kept and `rx_full` stays 1.
- R10: An accepted `rx_done` with `rx_par_in` or `rx_frm_in` high sets `par_err` or `frm_err` respectively. The flags stay set through reads.
- R11: `err_clr` clears all three error flags at the next edge. If an error is raised in the same cycle, that new error sets its flag and wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_done | input | 1 | Character-complete strobe from receive shifter |
| rx_byte | input | 8 | Received character |
| rx_par_in | input | 1 | Parity error of the completing character |
| rx_frm_in | input | 1 | Framing error of the completing character |
| char7_mode | input | 1 | 1 = 7-bit characters |
| brk_det | input | 1 | Line break detected |
| rx_irq_en | input | 1 | Receive interrupt enable |
| bus_rd | input | 1 | Bus read strobe of the data address |
| bus_wr | input | 1 | Bus write strobe of the data address |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Receive register contents |
| err_clr | input | 1 | Clear all error flags |
| tx_data | output | 8 | Transmit register contents |
| rx_full | output | 1 | Receive data full flag |
| par_err | output | 1 | Parity error flag |
| ovr_err | output | 1 | Overrun error flag |
| frm_err | output | 1 | Framing error flag |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
Every stored result (receive byte, transmit byte, full flag and error flags) becomes visible one rising edge after the strobe that causes it. `rx_irq` and `bus_rdata` are combinational views of those registers, so they change on that same edge. After `rst_n` rises, the internal reset releases two edges later, and the bench waits past that point before its first strobe. Inputs are driven at the falling edge, held across exactly one rising edge, and the outputs are sampled at the next falling edge. This means each check sees the state exactly one register stage after its stimulus.

// File: rtl/sio_dreg_pkg.sv
package sio_dreg_pkg;
  typedef struct packed {
    logic par;
    logic ovr;
    logic frm;
  } sio_err_t;
endpackage

// File: rtl/sio_rst_sync.sv
module sio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/sio_rx_capture.sv
module sio_rx_capture #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic          char7,
  input  logic [DW-1:0] rx_byte,
  output logic [DW-1:0] rx_q
);
  localparam int MSB = DW - 1;
  logic [DW-1:0] rx_d;

  // top bit forced low for short characters
  always_comb begin
    rx_d = rx_byte;
    if (char7) rx_d[MSB] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rx_q <= '0;
    else if (load_en) rx_q <= rx_d;
  end
endmodule

// File: rtl/sio_rx_status.sv
module sio_rx_status
  import sio_dreg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     rx_done,
  input  logic     bus_rd,
  input  logic     brk_det,
  input  logic     err_clr,
  input  logic     par_in,
  input  logic     frm_in,
  output logic     load_en,
  output logic     full_q,
  output sio_err_t err_q
);
  logic     full_d;
  sio_err_t err_d;
  logic     accept;
  logic     ovr_evt;

  always_comb begin
    accept  = rx_done & ~brk_det;
    ovr_evt = accept & full_q & ~bus_rd;
    load_en = accept & ~ovr_evt;

    if (brk_det)      full_d = 1'b0;
    else if (load_en) full_d = 1'b1;
    else if (bus_rd)  full_d = 1'b0;
    else              full_d = full_q;

    // a new error wins over a clear in the same cycle
    err_d.par = (err_q.par & ~err_clr) | (accept & par_in);
    err_d.frm = (err_q.frm & ~err_clr) | (accept & frm_in);
    err_d.ovr = (err_q.ovr & ~err_clr) | ovr_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      err_q  <= '0;
    end else begin
      full_q <= full_d;
      err_q  <= err_d;
    end
  end
endmodule

// File: rtl/sio_tx_hold.sv
module sio_tx_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] tx_q
);
  localparam logic [DW-1:0] RST_VAL = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tx_q <= RST_VAL;
    else if (wr_en) tx_q <= wdata;
  end
endmodule

// File: rtl/sio_data_port.sv
module sio_data_port
  import sio_dreg_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_done,
  input  logic [DW-1:0] rx_byte,
  input  logic          rx_par_in,
  input  logic          rx_frm_in,
  input  logic          char7_mode,
  input  logic          brk_det,
  input  logic          rx_irq_en,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          err_clr,
  output logic [DW-1:0] tx_data,
  output logic          rx_full,
  output logic          par_err,
  output logic          ovr_err,
  output logic          frm_err,
  output logic          rx_irq
);
  logic     rst_sync_n;
  logic     load_en;
  sio_err_t err_q;

  sio_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  sio_rx_status u_stat (
    .clk(clk), .rst_n(rst_sync_n), .rx_done(rx_done), .bus_rd(bus_rd),
    .brk_det(brk_det), .err_clr(err_clr), .par_in(rx_par_in),
    .frm_in(rx_frm_in), .load_en(load_en), .full_q(rx_full), .err_q(err_q)
  );

  sio_rx_capture #(.DW(DW)) u_cap (
    .clk(clk), .rst_n(rst_sync_n), .load_en(load_en), .char7(char7_mode),
    .rx_byte(rx_byte), .rx_q(bus_rdata)
  );

  sio_tx_hold #(.DW(DW)) u_tx (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(bus_wr), .wdata(bus_wdata),
    .tx_q(tx_data)
  );

  assign par_err = err_q.par;
  assign ovr_err = err_q.ovr;
  assign frm_err = err_q.frm;
  // request stays up while data is waiting or any error is pending
  assign rx_irq  = rx_irq_en & (rx_full | err_q.par | err_q.ovr | err_q.frm);
endmodule

// File: rtl/sio_data_port_chk.sv
module sio_data_port_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_sync_n,
  input logic          rx_done,
  input logic          char7_mode,
  input logic          brk_det,
  input logic          bus_rd,
  input logic          err_clr,
  input logic          rx_irq_en,
  input logic [DW-1:0] bus_rdata,
  input logic          rx_full,
  input logic          par_err,
  input logic          ovr_err,
  input logic          frm_err,
  input logic          rx_irq
);
  a_r4_full_on_done: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rx_done && !brk_det) |=> rx_full);

  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_rd && !rx_done) |=> !rx_full);

  a_r8_break_clears: assert property (@(posedge clk) disable iff (!rst_sync_n)
    brk_det |=> !rx_full);

  a_r8_break_holds_data: assert property (@(posedge clk) disable iff (!rst_sync_n)
    brk_det |=> (bus_rdata == $past(bus_rdata)));

  a_r9_overrun: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rx_done && rx_full && !bus_rd && !brk_det) |=> (ovr_err && bus_rdata == $past(bus_rdata)));

  a_r3_msb_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rx_done && char7_mode && !rx_full && !brk_det) |=> !bus_rdata[DW-1]);

  a_r5_irq_full: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rx_irq_en && rx_full) |-> rx_irq);

  a_r5_irq_masked: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rx_irq_en |-> !rx_irq);

  a_r7_irq_err: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rx_irq_en && (par_err || ovr_err || frm_err)) |-> rx_irq);

  a_r10_par_sticky: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (par_err && !err_clr) |=> par_err);

  a_r11_clear: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (err_clr && !rx_done) |=> !(par_err || ovr_err || frm_err));
endmodule

bind sio_data_port sio_data_port_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .rx_done(rx_done),
  .char7_mode(char7_mode), .brk_det(brk_det), .bus_rd(bus_rd),
  .err_clr(err_clr), .rx_irq_en(rx_irq_en), .bus_rdata(bus_rdata),
  .rx_full(rx_full), .par_err(par_err), .ovr_err(ovr_err),
  .frm_err(frm_err), .rx_irq(rx_irq)
);

// File: tb/sio_data_port_tb.sv
`timescale 1ns/1ps
module sio_data_port_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_done = 0, rx_par_in = 0, rx_frm_in = 0, char7_mode = 0;
  logic brk_det = 0, rx_irq_en = 0, bus_rd = 0, bus_wr = 0, err_clr = 0;
  logic [7:0] rx_byte = 0, bus_wdata = 0;
  logic [7:0] bus_rdata, tx_data;
  logic rx_full, par_err, ovr_err, frm_err, rx_irq;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  sio_data_port u_dut (
    .clk(clk), .rst_n(rst_n), .rx_done(rx_done), .rx_byte(rx_byte),
    .rx_par_in(rx_par_in), .rx_frm_in(rx_frm_in), .char7_mode(char7_mode),
    .brk_det(brk_det), .rx_irq_en(rx_irq_en), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .err_clr(err_clr), .tx_data(tx_data), .rx_full(rx_full),
    .par_err(par_err), .ovr_err(ovr_err), .frm_err(frm_err), .rx_irq(rx_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // hold the set strobes across one rising edge, then drop them
  task automatic tick();
    @(negedge clk);
    rx_done = 0; rx_par_in = 0; rx_frm_in = 0; brk_det = 0;
    bus_rd = 0; bus_wr = 0; err_clr = 0;
  endtask

  task automatic recv(input logic [7:0] b);
    rx_byte = b; rx_done = 1; tick();
  endtask

  task automatic rd();
    bus_rd = 1; tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R2 reset state
    chk("R2 rdata", bus_rdata, 8'h00);
    chk("R2 tx", tx_data, 8'hFF);
    chk("R2 flags", {rx_full, par_err, ovr_err, frm_err, rx_irq}, 5'b0);

    // R1 shared address
    bus_wdata = 8'h5A; bus_wr = 1; tick();
    chk("R1 tx write", tx_data, 8'h5A);
    chk("R1 rx untouched by write", bus_rdata, 8'h00);
    chk("R1 full untouched by write", rx_full, 1'b0);
    recv(8'hC3);
    rd();
    chk("R1 tx untouched by read", tx_data, 8'h5A);
    chk("R1 read data", bus_rdata, 8'hC3);

    // R3 R4 R6 sweep over both character lengths and every byte
    for (int m = 0; m < 2; m++) begin
      char7_mode = m[0];
      for (int b = 0; b < 256; b++) begin
        recv(b[7:0]);
        chk("R3 stored byte", bus_rdata, m ? (b & 8'h7F) : b[7:0]);
        chk("R4 full set", rx_full, 1'b1);
        rd();
        chk("R6 full cleared", rx_full, 1'b0);
      end
    end
    char7_mode = 0;

    // R5 interrupt
    rx_irq_en = 1;
    chk("R5 idle no irq", rx_irq, 1'b0);
    recv(8'h33);
    chk("R5 irq raised", rx_irq, 1'b1);
    rd();
    chk("R5 irq dropped on read", rx_irq, 1'b0);
    rx_irq_en = 0;
    recv(8'h34);
    chk("R5 masked irq", rx_irq, 1'b0);
    chk("R5 masked full", rx_full, 1'b1);
    rd();

    // R6 read and complete in one cycle
    recv(8'h44);
    rx_byte = 8'h55; rx_done = 1; bus_rd = 1; tick();
    chk("R6 simultaneous data", bus_rdata, 8'h55);
    chk("R6 simultaneous full", rx_full, 1'b1);
    chk("R6 simultaneous no overrun", ovr_err, 1'b0);
    rd();

    // R9 overrun, R7 irq held, R11 clear
    rx_irq_en = 1;
    recv(8'h11);
    recv(8'h22);
    chk("R9 overrun flag", ovr_err, 1'b1);
    chk("R9 old byte kept", bus_rdata, 8'h11);
    chk("R9 full kept", rx_full, 1'b1);
    rd();
    chk("R7 full cleared", rx_full, 1'b0);
    chk("R7 irq held by error", rx_irq, 1'b1);
    err_clr = 1; tick();
    chk("R11 overrun cleared", ovr_err, 1'b0);
    chk("R11 irq gone", rx_irq, 1'b0);

    // R8 break
    recv(8'h66);
    brk_det = 1; tick();
    chk("R8 break clears full", rx_full, 1'b0);
    chk("R8 break irq", rx_irq, 1'b0);
    rx_byte = 8'h77; rx_done = 1; rx_par_in = 1; brk_det = 1; tick();
    chk("R8 done ignored data", bus_rdata, 8'h66);
    chk("R8 done ignored full", rx_full, 1'b0);
    chk("R8 done ignored parity", par_err, 1'b0);

    // R10 parity and framing flags
    rx_byte = 8'h81; rx_done = 1; rx_par_in = 1; tick();
    chk("R10 parity set", par_err, 1'b1);
    chk("R10 data stored", bus_rdata, 8'h81);
    rd();
    chk("R10 parity sticky", par_err, 1'b1);
    chk("R10 framing clear", frm_err, 1'b0);
    rx_byte = 8'h82; rx_done = 1; rx_frm_in = 1; tick();
    chk("R10 framing set", frm_err, 1'b1);
    rd();
    chk("R10 framing sticky", frm_err, 1'b1);

    // R11 set beats clear
    rx_byte = 8'h90; rx_done = 1; rx_par_in = 1; err_clr = 1; tick();
    chk("R11 set wins parity", par_err, 1'b1);
    chk("R11 framing cleared", frm_err, 1'b0);
    rd();
    err_clr = 1; tick();
    chk("R11 all cleared", {par_err, ovr_err, frm_err}, 3'b000);
    chk("R11 no irq", rx_irq, 1'b0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule